// File: doc/BRIEF.md
# Lockable Security Register Bank

This block is a bank of one-time-programmable security registers that sits inside a memory device. It holds seventeen registers of 128 bits each. Every register is reached as a run of 16-bit words through one command port. Register 0 is split into two 64-bit halves. The lower half carries a fixed factory identifier. The upper half is free for the user. Registers 1 to 16 each form a single user segment. That gives eighteen segments in all, and each one has its own lock bit.

The bank behaves like erased non-volatile cells. User words start as all ones, and a program can only pull bits low. Lock bits follow the same one-way rule, so a lock can never be undone. The lock bits are packed into lock words that sit just above the register words in the same address space. They are read and programmed through the same commands as the data.

A program that the bank refuses raises a sticky error flag. A refused program is one aimed at a locked segment, at the factory half, or at an address beyond the map. Only an explicit clear command lowers the flag. Cell physics and program timing are not modelled: storage is a set of flops loaded at reset.

Top module: `secreg_bank`

## Requirements
- R1: After reset: factory words 0..3 read 16'hD468, 16'h0B92, 16'h1E7F, 16'hA5C3 (low word first); every user word reads 16'hFFFF; lock word 136 reads 16'hFFFE; lock word 137 reads 16'hFFFF; `rd_valid` and `err_flag` are 0.
- R2: `cmd_op` encodes read=0, program=1, clear-error=2, idle=3. A read accepted on a clock edge drives `rd_valid` high with the word on `rd_data` after that same edge. `rd_valid` is low after every edge that did not accept a read.
- R3: An accepted program to an open user word stores the old word ANDed with `cmd_data`, so bits only go from 1 to 0.
- R4: Words 0..3 (the factory half) never change. A program to them is refused.
- R5: A program to lock word 136 or 137 ANDs its data into the lock bits, so writing 1 never unlocks. The factory lock bit (bit 0 of word 136) always reads 0.
- R6: A program to a segment whose lock bit is 0 leaves that segment unchanged and sets `err_flag`.
- R7: A program to an address of 138 or above changes nothing and sets `err_flag`. A read there returns 16'hFFFF.
- R8: `err_flag` stays high through later reads and through successful programs. Only a clear-error command lowers it.
- R9: Address map: words 0..3 are the factory half, 4..7 are the user half of register 0, and register k (1..16) is at 8k..8k+7. Segment s (0 factory, 1 register-0 user half, k+1 register k) has its lock bit at word 136+s/16, bit s%16. Locking one segment leaves the others programmable.
- R10: A read issued in the cycle after a program returns the programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, reloads storage |
| cmd_valid | input | 1 | Command accepted on this edge |
| cmd_op | input | 2 | Command code: read, program, clear-error, idle |
| cmd_addr | input | 8 | Word address (register words, then lock words) |
| cmd_data | input | 16 | Program data, ANDed into the target |
| rd_valid | output | 1 | Read result present on `rd_data` |
| rd_data | output | 16 | Read result |
| err_flag | output | 1 | Sticky refused-program flag |

## Verification
The bench programs the same word twice with overlapping masks. A design that overwrote the word instead of ANDing it would return the second mask rather than the intersection. It programs the factory half and a locked segment and then reads them back. A missing lock gate would show altered data there, and the error flag would stay low. It locks register 0's user half and then programs register 1. This catches an off-by-one in the segment decode, because the wrong segment would refuse the program. It writes ones to a lock word to check that locking cannot be undone. It also programs past the map and runs successful programs while the error flag is set. A flag that cleared by itself, or a missing range check, would show at the ports.

// File: rtl/secreg_pkg.sv
package secreg_pkg;

    localparam int unsigned WORD_W    = 16;
    localparam int unsigned SEG_WORDS = 4;
    localparam int unsigned NUM_REGS  = 17;

    localparam int unsigned SEG_BITS    = WORD_W * SEG_WORDS;
    localparam int unsigned REG_WORDS   = 2 * SEG_WORDS;
    localparam int unsigned NUM_SEGS    = NUM_REGS + 1;
    localparam int unsigned ARRAY_WORDS = NUM_REGS * REG_WORDS;
    localparam int unsigned LOCK_WORDS  = (NUM_SEGS + WORD_W - 1) / WORD_W;
    localparam int unsigned ADDR_SPAN   = ARRAY_WORDS + LOCK_WORDS;
    localparam int unsigned ADDR_W      = $clog2(ADDR_SPAN);
    localparam int unsigned SEG_W       = $clog2(NUM_SEGS);
    localparam int unsigned LIDX_W      = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;

    localparam logic [SEG_BITS-1:0] FACTORY_ID = 64'hA5C3_1E7F_0B92_D468;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_CLEAR = 2'd2,
        OP_IDLE  = 2'd3
    } op_e;

    typedef struct packed {
        logic              in_array;
        logic              in_lock;
        logic              out_of_range;
        logic [SEG_W-1:0]  seg;
        logic [LIDX_W-1:0] lock_idx;
    } dec_t;

    // Segment that owns an array word: register 0 holds two segments,
    // every later register holds one.
    function automatic logic [SEG_W-1:0] seg_of(input logic [ADDR_W-1:0] a);
        int unsigned ai;
        ai = 32'(a);
        if (ai < REG_WORDS) return SEG_W'(ai / SEG_WORDS);
        return SEG_W'(ai / REG_WORDS + 1);
    endfunction

endpackage

// File: rtl/secreg_decode.sv
module secreg_decode
    import secreg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        int unsigned ai;
        ai  = 32'(addr);
        dec = '0;
        if (ai < ARRAY_WORDS) begin
            dec.in_array = 1'b1;
            dec.seg      = seg_of(addr);
        end else if (ai < ADDR_SPAN) begin
            dec.in_lock  = 1'b1;
            dec.lock_idx = LIDX_W'(ai - ARRAY_WORDS);
        end else begin
            dec.out_of_range = 1'b1;
        end
    end

endmodule

// File: rtl/secreg_lock.sv
module secreg_lock
    import secreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [LIDX_W-1:0]   idx,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [NUM_SEGS-1:0] locks,
    output logic [WORD_W-1:0]   rd_word
);

    logic [NUM_SEGS-1:0] lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= {{(NUM_SEGS-1){1'b1}}, 1'b0};
        end else if (wr_en) begin
            for (int s = 0; s < NUM_SEGS; s++) begin
                if (s / WORD_W == int'(idx))
                    lock_q[s] <= lock_q[s] & wr_data[s % WORD_W];
            end
        end
    end

    always_comb begin
        for (int b = 0; b < WORD_W; b++) begin
            int sg;
            sg = int'(idx) * WORD_W + b;
            rd_word[b] = (sg < NUM_SEGS) ? lock_q[SEG_W'(sg)] : 1'b1;
        end
    end

    assign locks = lock_q;

    // R5: factory segment never reports open
    a_r5_factory_locked: assert property (@(posedge clk) disable iff (rst)
        !lock_q[0]);

    // R5: no lock bit ever returns from 0 to 1
    a_r5_one_way: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((lock_q & ~$past(lock_q)) == '0));

endmodule

// File: rtl/secreg_store.sv
module secreg_store
    import secreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [ARRAY_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARRAY_WORDS; i++)
                mem[i] <= (i < SEG_WORDS) ? FACTORY_ID[i*WORD_W +: WORD_W] : '1;
        end else if (wr_en) begin
            mem[addr] <= mem[addr] & wr_data;
        end
    end

    assign rd_data = (32'(addr) < ARRAY_WORDS) ? mem[addr] : '1;

    // R4: write strobe from the top never targets the factory half
    a_r4_no_factory_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (32'(addr) >= SEG_WORDS));

    generate
        for (genvar w = 0; w < SEG_WORDS; w++) begin : g_fid
            // R4: factory words keep their preset value
            a_r4_factory_fixed: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> $stable(mem[w]));
        end
    endgenerate

endmodule

// File: rtl/secreg_bank.sv
module secreg_bank
    import secreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              err_flag
);

    dec_t                dec;
    op_e                 op;
    logic [NUM_SEGS-1:0] lock_vec;
    logic [WORD_W-1:0]   store_rd;
    logic [WORD_W-1:0]   lock_rd;
    logic                is_read, is_prog, is_clear;
    logic                seg_open, store_wr, lock_wr, refuse;

    assign op       = op_e'(cmd_op);
    assign is_read  = cmd_valid && (op == OP_READ);
    assign is_prog  = cmd_valid && (op == OP_PROG);
    assign is_clear = cmd_valid && (op == OP_CLEAR);

    secreg_decode u_dec (
        .addr (cmd_addr),
        .dec  (dec)
    );

    assign seg_open = lock_vec[dec.seg];
    assign store_wr = is_prog && dec.in_array && seg_open;
    assign lock_wr  = is_prog && dec.in_lock;
    assign refuse   = is_prog && (dec.out_of_range || (dec.in_array && !seg_open));

    secreg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store_wr),
        .addr    (cmd_addr),
        .wr_data (cmd_data),
        .rd_data (store_rd)
    );

    secreg_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lock_wr),
        .idx     (dec.lock_idx),
        .wr_data (cmd_data),
        .locks   (lock_vec),
        .rd_word (lock_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            err_flag <= 1'b0;
        end else begin
            rd_valid <= is_read;
            if (is_read)
                rd_data <= dec.in_array ? store_rd :
                           dec.in_lock  ? lock_rd  : '1;
            if (is_clear)
                err_flag <= 1'b0;
            else if (refuse)
                err_flag <= 1'b1;
        end
    end

    // R2: a read always yields a result next cycle
    a_r2_read_answers: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd0) |=> rd_valid);

    // R2: no result without a read
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_op == 2'd0) |=> !rd_valid);

    // R8: error flag only drops on a clear command
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !(cmd_valid && cmd_op == 2'd2)) |=> err_flag);

    // R7: a program beyond the map is flagged
    a_r7_range_refused: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1 && dec.out_of_range) |=> err_flag);

    // R6: a program to a closed segment is flagged
    a_r6_locked_flagged: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1 && dec.in_array && !lock_vec[dec.seg]) |=> err_flag);

endmodule

// File: tb/secreg_bank_tb.sv
module secreg_bank_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] C_READ  = 2'd0;
    localparam logic [1:0] C_PROG  = 2'd1;
    localparam logic [1:0] C_CLEAR = 2'd2;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_addr;
    logic [15:0] cmd_data;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        err_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secreg_bank u_dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .err_flag  (err_flag)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one command for one edge; returns at the following falling edge.
    task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'd3;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        issue(C_READ, a, 16'h0);
        check(req, {15'h0, rd_valid}, 16'h1);
        check(req, rd_data, exp);
    endtask

    task automatic t_reset;
        check("R1 rd_valid", {15'h0, rd_valid}, 16'h0);
        check("R1 err", {15'h0, err_flag}, 16'h0);
        read_chk("R1 fid0", 8'd0, 16'hD468);
        read_chk("R1 fid1", 8'd1, 16'h0B92);
        read_chk("R1 fid2", 8'd2, 16'h1E7F);
        read_chk("R1 fid3", 8'd3, 16'hA5C3);
        read_chk("R1 R9 user0", 8'd4, 16'hFFFF);
        read_chk("R1 R9 reg1", 8'd8, 16'hFFFF);
        read_chk("R1 R9 reg16 last", 8'd135, 16'hFFFF);
        read_chk("R1 R5 lock0", 8'd136, 16'hFFFE);
        read_chk("R1 lock1", 8'd137, 16'hFFFF);
    endtask

    task automatic t_timing;
        issue(C_READ, 8'd0, 16'h0);
        check("R2 valid after read", {15'h0, rd_valid}, 16'h1);
        @(negedge clk);
        check("R2 valid drops", {15'h0, rd_valid}, 16'h0);
        issue(C_PROG, 8'd20, 16'hFFFF);
        check("R2 no valid on program", {15'h0, rd_valid}, 16'h0);
    endtask

    task automatic t_and_prog;
        issue(C_PROG, 8'd8, 16'hF0F0);
        read_chk("R3 R10 first program", 8'd8, 16'hF0F0);
        issue(C_PROG, 8'd8, 16'h0FFF);
        read_chk("R3 AND merge", 8'd8, 16'h00F0);
        issue(C_PROG, 8'd5, 16'h1234);
        read_chk("R3 R9 reg0 user half", 8'd5, 16'h1234);
        check("R3 no error", {15'h0, err_flag}, 16'h0);
    endtask

    task automatic t_factory;
        issue(C_PROG, 8'd1, 16'h0000);
        check("R4 factory refused", {15'h0, err_flag}, 16'h1);
        read_chk("R4 factory unchanged", 8'd1, 16'h0B92);
        issue(C_CLEAR, 8'd0, 16'h0);
        check("R8 clear", {15'h0, err_flag}, 16'h0);
    endtask

    task automatic t_lock;
        issue(C_PROG, 8'd136, 16'hFFFD);
        read_chk("R5 R9 lock seg1", 8'd136, 16'hFFFC);
        check("R5 lock write no error", {15'h0, err_flag}, 16'h0);
        issue(C_PROG, 8'd6, 16'h0000);
        check("R6 locked flagged", {15'h0, err_flag}, 16'h1);
        read_chk("R6 locked unchanged", 8'd6, 16'hFFFF);
        issue(C_CLEAR, 8'd0, 16'h0);
        issue(C_PROG, 8'd9, 16'hFF00);
        check("R9 reg1 still open", {15'h0, err_flag}, 16'h0);
        read_chk("R9 reg1 programmed", 8'd9, 16'hFF00);
        issue(C_PROG, 8'd136, 16'hFFFF);
        read_chk("R5 cannot unlock", 8'd136, 16'hFFFC);
        issue(C_PROG, 8'd137, 16'hFFFD);
        read_chk("R5 R9 lock seg17", 8'd137, 16'hFFFD);
        issue(C_PROG, 8'd130, 16'h0000);
        check("R6 reg16 flagged", {15'h0, err_flag}, 16'h1);
        read_chk("R6 reg16 unchanged", 8'd130, 16'hFFFF);
        issue(C_CLEAR, 8'd0, 16'h0);
        issue(C_PROG, 8'd127, 16'h0F0F);
        check("R9 reg15 open", {15'h0, err_flag}, 16'h0);
        read_chk("R9 reg15 programmed", 8'd127, 16'h0F0F);
    endtask

    task automatic t_range;
        issue(C_PROG, 8'd200, 16'h0000);
        check("R7 range flagged", {15'h0, err_flag}, 16'h1);
        read_chk("R7 range read", 8'd200, 16'hFFFF);
        read_chk("R7 lock untouched", 8'd137, 16'hFFFD);
        check("R8 held over read", {15'h0, err_flag}, 16'h1);
        issue(C_PROG, 8'd10, 16'h1234);
        check("R8 held over good program", {15'h0, err_flag}, 16'h1);
        read_chk("R3 program while flagged", 8'd10, 16'h1234);
        issue(C_CLEAR, 8'd0, 16'h0);
        check("R8 cleared", {15'h0, err_flag}, 16'h0);
    endtask

    initial begin
        rst       = 1'b1;
        cmd_valid = 1'b0;
        cmd_op    = 2'd3;
        cmd_addr  = '0;
        cmd_data  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_timing();
        t_and_prog();
        t_factory();
        t_lock();
        t_range();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule